// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

A small synchronous single-port memory for a cache or processor data path. The address, the cycle controls and the write data are captured on a rising clock edge. The following edge commits a write to the array or loads the read data into an output register. Read data therefore reaches the output one cycle after its address was presented. The word is 36 bits wide and holds four lanes of nine bits. Lane `i` is data bits `8i+7..8i` plus check bit `32+i`. Writes can cover the whole word or any set of lanes.

Two active-low start strobes begin an access: a processor strobe, which only ever starts a read, and a controller strobe, which may start a read or a write. Once an access is running, the cycles that follow without a strobe continue it at whatever address the external burst address generator now supplies. These continuation cycles honour the write controls. A strobe seen while the chip select is low deselects the block, and one cycle later the output stops driving. A doze input freezes all activity and keeps the stored contents. The first cycle after doze ends is always a deselect.

The cycle machine has four states: `ST_IDLE` (deselected), `ST_READ` (a read is held in the capture stage), `ST_WRITE` (a write is held in the capture stage) and `ST_SLEEP` (dozing). Its transitions are:
- doze high from any state goes to `ST_SLEEP`.
- `ST_SLEEP` with doze low goes to `ST_IDLE` (the wake deselect).
- A strobe with the select low goes to `ST_IDLE` (a deselect).
- A processor strobe with the select high goes to `ST_READ`.
- A controller strobe with the select high, or a cycle with no strobe from `ST_READ` or `ST_WRITE`, goes to `ST_WRITE` when a write is requested and to `ST_READ` otherwise.
- A cycle with no strobe in `ST_IDLE` stays in `ST_IDLE`.

Top module: `pbsram_byte`

## Requirements
- R1: With `wr_all_n` low at an accepted write edge, all four lanes of `din` are stored at `addr`, whatever `lane_gate_n` and `lane_wr_n` are.
- R2: With `lane_gate_n` high and `wr_all_n` high, `lane_wr_n` is ignored and the addressed word keeps its contents.
- R3: With `lane_gate_n` low and `wr_all_n` high, every lane whose `lane_wr_n[i]` is low is written and the others are kept. Lane i is `din[8i+7:8i]` plus `din[32+i]`, and any combination of lanes can be written in one cycle.
- R4: A read captured on edge k places the word on `dout` after edge k+1, not after edge k. `dout_en` is high in the cycle after edge k+1 when `oe_n` is low and no write is requested.
- R5: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge.
- R6: While `wr_all_n` is low, or while `lane_gate_n` is low with any `lane_wr_n` bit low, `dout_en` is low at once. `lane_wr_n` alone, with the gate high, does not turn the drive off.
- R7: A strobe with `chip_sel` low ends the access: `dout_en` is low after the second edge that follows. Cycles with no strobe while deselected change no stored word.
- R8: A cycle started by `cpu_start_n` is a read even when write controls are active. It changes nothing and returns the addressed word.
- R9: Cycles with no strobe that follow a started access continue it at the current `addr`. They read, or write when the write controls ask for it, including after a processor-started access.
- R10: While `doze` is high, `dout_en` is low, all strobes and write controls are ignored, and the stored words are kept.
- R11: The first edge with `doze` low after dozing is a deselect, even if a strobe and a write are presented. An access needs a fresh strobe after that.
- R12: During and right after reset, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| doze | input | 1 | Low-power hold; contents kept |
| chip_sel | input | 1 | Chip select, active high |
| cpu_start_n | input | 1 | Processor start strobe (read only), active low |
| ctl_start_n | input | 1 | Controller start strobe, active low |
| addr | input | ADDR_W | Word address from the burst address generator |
| wr_all_n | input | 1 | Write all lanes, active low, highest priority |
| lane_gate_n | input | 1 | Enables the per-lane write selects, active low |
| lane_wr_n | input | NBYTES | Per-lane write selects, active low |
| din | input | DATA_W | Write data, lanes then check bits |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The hardest situations to reach from the ports are the wake edge and the write-in-continuation path. On the wake edge the block must throw away a fully valid write strobe. In a continuation write, no strobe is present and the write relies only on the state left by an earlier start. The bench reaches the first by holding doze for several cycles with writes presented, then releasing it with a controller-strobed write still applied. It reaches the second by starting an access with a read, including one begun by the processor strobe, and then presenting write controls with both strobes high. Both cases are judged by reading the target words back through normal accesses.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

    // Capture-stage state of the access pipeline
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } cyc_state_e;

endpackage

// File: rtl/pbsram_wr_decode.sv
module pbsram_wr_decode #(
    parameter int NBYTES = 4
) (
    input  logic              wr_all_n,
    input  logic              lane_gate_n,
    input  logic [NBYTES-1:0] lane_wr_n,
    output logic [NBYTES-1:0] lane_en,
    output logic              wr_req
);

    // Global write wins; lane selects only pass when the gate is open
    always_comb begin
        if (!wr_all_n) begin
            lane_en = '1;
        end else if (!lane_gate_n) begin
            lane_en = ~lane_wr_n;
        end else begin
            lane_en = '0;
        end
    end

    assign wr_req = |lane_en;

endmodule

// File: rtl/pbsram_cycle_fsm.sv
module pbsram_cycle_fsm
    import pbsram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       doze,
    input  logic       chip_sel,
    input  logic       cpu_start_n,
    input  logic       ctl_start_n,
    input  logic       wr_req,
    output cyc_state_e state,
    output logic       load,
    output logic       do_read,
    output logic       do_write
);

    cyc_state_e nxt;
    logic       any_strobe;

    assign any_strobe = !cpu_start_n || !ctl_start_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SLEEP: begin
                nxt = doze ? ST_SLEEP : ST_IDLE;
            end
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (doze) begin
                    nxt = ST_SLEEP;
                end else if (any_strobe && !chip_sel) begin
                    nxt = ST_IDLE;
                end else if (!cpu_start_n) begin
                    nxt = ST_READ;
                end else if (!ctl_start_n || state != ST_IDLE) begin
                    nxt = wr_req ? ST_WRITE : ST_READ;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load     = (nxt == ST_READ) || (nxt == ST_WRITE);
        do_read  = (state == ST_READ);
        do_write = (state == ST_WRITE);
    end

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NBYTES*(BYTE_W+1)-1:0]        din,
    input  logic [NBYTES-1:0]                   lane_en,
    input  logic                                do_read,
    input  logic                                do_write,
    output logic [NBYTES*(BYTE_W+1)-1:0]        rdata,
    output logic                                rd_valid
);

    localparam int DATA_W = NBYTES * (BYTE_W + 1);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CHK_LO = NBYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [NBYTES-1:0] lane_q;
    logic [DATA_W-1:0] bit_we;

    // Expand lane enables to a bit mask: data bits, then one check bit per lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign bit_we[b*BYTE_W +: BYTE_W] = {BYTE_W{lane_q[b]}};
        assign bit_we[CHK_LO + b]         = lane_q[b];
    end

    // Capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            din_q  <= '0;
            lane_q <= '0;
        end else if (load) begin
            addr_q <= addr;
            din_q  <= din;
            lane_q <= lane_en;
        end
    end

    // Array commit; contents are not reset
    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[addr_q] <= (mem[addr_q] & ~bit_we) | (din_q & bit_we);
        end
    end

    // Output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= do_read;
            if (do_read) begin
                rdata <= mem[addr_q];
            end
        end
    end

endmodule

// File: rtl/pbsram_byte.sv
module pbsram_byte
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          doze,
    input  logic                          chip_sel,
    input  logic                          cpu_start_n,
    input  logic                          ctl_start_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr_all_n,
    input  logic                          lane_gate_n,
    input  logic [NBYTES-1:0]             lane_wr_n,
    input  logic [NBYTES*(BYTE_W+1)-1:0]  din,
    input  logic                          oe_n,
    output logic [NBYTES*(BYTE_W+1)-1:0]  dout,
    output logic                          dout_en
);

    localparam int DATA_W = NBYTES * (BYTE_W + 1);

    cyc_state_e        state;
    logic [NBYTES-1:0] lane_en;
    logic              wr_req;
    logic              load;
    logic              do_read;
    logic              do_write;
    logic              rd_valid;
    logic [DATA_W-1:0] rdata;

    pbsram_wr_decode #(.NBYTES(NBYTES)) u_dec (
        .wr_all_n    (wr_all_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .lane_en     (lane_en),
        .wr_req      (wr_req)
    );

    pbsram_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .doze        (doze),
        .chip_sel    (chip_sel),
        .cpu_start_n (cpu_start_n),
        .ctl_start_n (ctl_start_n),
        .wr_req      (wr_req),
        .state       (state),
        .load        (load),
        .do_read     (do_read),
        .do_write    (do_write)
    );

    pbsram_array #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr     (addr),
        .din      (din),
        .lane_en  (lane_en),
        .do_read  (do_read),
        .do_write (do_write),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    // Drive only for a held read, output enabled, awake, and no write on the bus
    assign dout    = rdata;
    assign dout_en = rd_valid && !oe_n && !doze && !wr_req;

endmodule

// File: rtl/pbsram_byte_chk.sv
module pbsram_byte_chk
    import pbsram_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              doze,
    input logic              chip_sel,
    input logic              cpu_start_n,
    input logic              ctl_start_n,
    input logic              wr_all_n,
    input logic              lane_gate_n,
    input logic [NBYTES-1:0] lane_wr_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input cyc_state_e        state
);

    logic bus_wr;
    logic strobe;
    assign bus_wr = !wr_all_n || (!lane_gate_n && !(&lane_wr_n));
    assign strobe = !cpu_start_n || !ctl_start_n;

    AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |=> (dout_en || oe_n || doze || bus_wr)); // R4

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en); // R5

    AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !dout_en); // R6

    AST_DESEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && state != ST_SLEEP && !chip_sel && strobe) |=> ##1 !dout_en); // R7

    AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && state != ST_SLEEP && chip_sel && !cpu_start_n) |=> (state == ST_READ)); // R8

    AST_DOZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |=> $stable(dout)); // R10

    AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !doze) |=> (state == ST_IDLE)); // R11

endmodule

bind pbsram_byte pbsram_byte_chk #(
    .NBYTES (NBYTES),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .doze        (doze),
    .chip_sel    (chip_sel),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .wr_all_n    (wr_all_n),
    .lane_gate_n (lane_gate_n),
    .lane_wr_n   (lane_wr_n),
    .oe_n        (oe_n),
    .dout        (dout),
    .dout_en     (dout_en),
    .state       (state)
);

// File: tb/pbsram_byte_bench.sv
`timescale 1ns/1ps
module pbsram_byte_bench;

    localparam int AW = 4;
    localparam int NB = 4;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          doze;
    logic          chip_sel;
    logic          cpu_start_n;
    logic          ctl_start_n;
    logic [AW-1:0] addr;
    logic          wr_all_n;
    logic          lane_gate_n;
    logic [NB-1:0] lane_wr_n;
    logic [DW-1:0] din;
    logic          oe_n;
    logic [DW-1:0] dout;
    logic          dout_en;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] ref_mem [1<<AW];

    pbsram_byte u_pbsram_byte (
        .clk(clk), .rst_n(rst_n), .doze(doze), .chip_sel(chip_sel),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .addr(addr),
        .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
        .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic idle_in;
        chip_sel = 0; cpu_start_n = 1; ctl_start_n = 1;
        wr_all_n = 1; lane_gate_n = 1; lane_wr_n = '1; oe_n = 0; doze = 0;
    endtask

    task automatic desel_in;
        idle_in;
        ctl_start_n = 0;
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        logic [31:0] lo;
        lo = 32'(k) * 32'h9E37_79B1 + 32'h0000_1234;
        return {4'(k) ^ 4'hA, lo};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NB-1:0] m);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < NB; i++) begin
            if (m[i]) begin
                r[8*i +: 8] = nw[8*i +: 8];
                r[32 + i]   = nw[32 + i];
            end
        end
        return r;
    endfunction

    task automatic do_write(input int a, input logic [DW-1:0] d, input logic g,
                            input logic be, input logic [NB-1:0] bw, input bit use_cpu);
        logic [NB-1:0] m;
        idle_in;
        chip_sel = 1;
        if (use_cpu) cpu_start_n = 0; else ctl_start_n = 0;
        addr = AW'(a); din = d; wr_all_n = g; lane_gate_n = be; lane_wr_n = bw;
        tick;
        desel_in;
        tick;
        idle_in;
        m = !g ? '1 : (!be ? ~bw : '0);
        if (!use_cpu) ref_mem[a] = merge(ref_mem[a], d, m);
    endtask

    task automatic do_read(input int a, input string req);
        idle_in;
        chip_sel = 1; ctl_start_n = 0; addr = AW'(a);
        tick;
        desel_in;
        tick;
        #1;
        check(req, dout, ref_mem[a]);
        check(req, dout_en, 1);
        idle_in;
        tick;
        #1;
        check("R7 drive off after deselect", dout_en, 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_in;
        addr = '0; din = '0;
        rst_n = 0;
        repeat (4) tick;
        check("R12 reset quiet", dout_en, 0);
        rst_n = 1;
        tick; tick;
        check("R12 after reset quiet", dout_en, 0);

        // R1: fill every word with a global write, read all back
        for (int a = 0; a < 16; a++) do_write(a, pat(a), 0, 1, '1, 0);
        for (int a = 0; a < 16; a++) do_read(a, "R1 global fill");

        // R1: global write beats any lane pattern with gate open
        for (int p = 0; p < 16; p++) begin
            do_write(5, pat(100 + p), 0, 0, 4'(p), 0);
            do_read(5, "R1 global priority");
        end

        // R3: every lane combination through the gate
        for (int p = 0; p < 16; p++) begin
            do_write(7, pat(200 + p), 1, 0, 4'(p), 0);
            do_read(7, "R3 lane write");
        end

        // R2: gate closed blocks all lane selects
        for (int p = 0; p < 16; p++) begin
            do_write(9, pat(300 + p), 1, 1, 4'(p), 0);
            do_read(9, "R2 gate closed");
        end

        // R8: processor-strobed cycle never writes and returns data
        do_write(2, pat(400), 0, 0, '0, 1);
        do_read(2, "R8 cpu start no write");
        idle_in; chip_sel = 1; cpu_start_n = 0; addr = 4; wr_all_n = 0; din = pat(401);
        tick;
        desel_in;
        tick; #1;
        check("R8 cpu start read data", dout, ref_mem[4]);
        idle_in; tick;
        do_read(4, "R8 cpu start kept word");

        // R4 / R9: pipeline timing and read continuation
        idle_in; chip_sel = 1; ctl_start_n = 0; addr = 1;
        tick; #1;
        check("R4 not yet driven", dout_en, 0);
        idle_in; addr = 6;
        tick; #1;
        check("R4 first word", dout, ref_mem[1]);
        check("R4 first word driven", dout_en, 1);
        desel_in;
        tick; #1;
        check("R9 continued read", dout, ref_mem[6]);
        idle_in; tick;

        // R5 / R6: asynchronous drive control
        idle_in; chip_sel = 1; ctl_start_n = 0; addr = 3;
        tick;
        desel_in;
        tick; #1;
        check("R4 driven", dout_en, 1);
        oe_n = 1; #1;
        check("R5 oe high", dout_en, 0);
        oe_n = 0; #1;
        check("R5 oe low again", dout_en, 1);
        wr_all_n = 0; #1;
        check("R6 global write off", dout_en, 0);
        wr_all_n = 1; lane_gate_n = 0; lane_wr_n = 4'b1101; #1;
        check("R6 lane write off", dout_en, 0);
        lane_gate_n = 1; #1;
        check("R6 gated lanes no effect", dout_en, 1);
        idle_in; tick;

        // R9: write inside a continuation after a controller read start
        idle_in; chip_sel = 1; ctl_start_n = 0; addr = 10;
        tick;
        idle_in; addr = 11; wr_all_n = 0; din = pat(500);
        tick;
        desel_in;
        tick;
        idle_in;
        ref_mem[11] = pat(500);
        do_read(11, "R9 continuation write");
        do_read(10, "R9 start word kept");

        // R9: continuation write after a processor start
        idle_in; chip_sel = 1; cpu_start_n = 0; addr = 12; wr_all_n = 0; din = pat(502);
        tick;
        idle_in; addr = 13; wr_all_n = 0; din = pat(501);
        tick;
        desel_in;
        tick;
        idle_in;
        ref_mem[13] = pat(501);
        do_read(13, "R9 continuation after cpu start");
        do_read(12, "R8 cpu start word kept");

        // R7: no-strobe cycles while deselected write nothing
        idle_in; addr = 14; wr_all_n = 0; din = pat(600);
        tick; tick;
        idle_in;
        do_read(14, "R7 idle no write");

        // R10 / R11: doze and wake
        idle_in; chip_sel = 1; ctl_start_n = 0; addr = 0;
        tick;
        idle_in; doze = 1;
        tick; #1;
        check("R10 doze no drive", dout_en, 0);
        for (int i = 0; i < 4; i++) begin
            chip_sel = 1; ctl_start_n = 0; wr_all_n = 0; addr = 0; din = pat(700 + i);
            tick; #1;
            check("R10 doze no drive", dout_en, 0);
        end
        doze = 0; chip_sel = 1; ctl_start_n = 0; wr_all_n = 0; addr = 1; din = pat(710);
        tick; #1;
        check("R11 wake deselect", dout_en, 0);
        ctl_start_n = 1; chip_sel = 0;
        tick;
        idle_in; tick;
        do_read(0, "R10 contents kept");
        do_read(1, "R11 wake write ignored");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule